// File: doc/BRIEF.md
# Serial Byte Memory Command Engine

This block is the slave side of a serial byte memory that speaks SPI mode 0. A host selects it with an active-low chip select and clocks bytes in MSB first on the rising edge of SCK. The first byte is a command. Array commands are followed by a 16-bit address, and the bits above the array width are ignored. The engine carries out sequential reads, page writes through a 32-byte page latch, status reads and writes, and write-enable control. Serial out changes after each falling edge of SCK and is driven only while the engine sends read data.

A write that is accepted starts a self-timed write cycle that lasts `WC_CYCLES` system clocks. While that cycle runs, the write-in-progress flag is set. When the cycle ends, the latched page bytes are stored and the write-enable latch is cleared. An external protection unit receives the two protection-select status bits. It can veto an array write through `arr_wr_block`, and it reports the state of the guard pin through `sr_guard`.

The array size is set by `ADDR_W`. The default is 11 bits (2048 bytes), and a full-size 8192-byte instance uses 13. SCK, chip select and serial in are resynchronised to `clk`, so SCK must run well below the system clock rate.

FSM states:
- `ST_IDLE`: deselected, or waiting for a chip-select falling edge.
- `ST_CMD`: shifting in the command byte.
- `ST_ADDR`: shifting in the 16 address bits.
- `ST_RDATA`: streaming array bytes out.
- `ST_WDATA`: shifting data bytes into the page latch.
- `ST_SRD`: streaming the status byte out.
- `ST_SWR`: shifting in the new status byte.
- `ST_SWR_ARM`: a status byte is complete and waits for chip select to rise.
- `ST_WE_ARM`: an enable or disable command is complete and waits for chip select to rise.
- `ST_SKIP`: the command is ignored until deselect.

FSM transitions:
- `ST_IDLE` to `ST_CMD` on a chip-select fall.
- From `ST_CMD` on the 8th bit:
  - to `ST_ADDR` for read, or for write when the latch is set and no write cycle runs;
  - to `ST_SRD` for status read;
  - to `ST_SWR` for status write when the latch is set and no write cycle runs;
  - to `ST_WE_ARM` for enable or disable when no write cycle runs;
  - to `ST_SKIP` otherwise.
- From `ST_ADDR` on the 16th bit: to `ST_RDATA` after a read command, or to `ST_WDATA` after a write command.
- `ST_SWR` to `ST_SWR_ARM` on the 8th bit.
- `ST_SWR_ARM` and `ST_WE_ARM` to `ST_SKIP` on any further SCK rise.
- Any state to `ST_IDLE` on a chip-select rise.

Top module: `ser_eeprom`

## Requirements
- R1: The command codes are 0x03 read, 0x02 write, 0x06 set write enable, 0x04 clear write enable, 0x05 read status and 0x01 write status. Any other code is ignored: serial out stays disabled, no state changes, and the engine waits until the next select.
- R2: Bits move MSB first. Input is sampled on the SCK rise, and serial out changes after the SCK fall. `sdo_en` is high only while the engine is selected in a read-data or status-read phase, and it is low in the cycle after chip select rises.
- R3: Read and write commands take a 16-bit address, and the address bits at positions ADDR_W and above are ignored.
- R4: A read returns successive bytes from an auto-incremented address and wraps from the last address to 0.
- R5: A write fills a 32-byte page latch starting at the address's in-page offset. The offset wraps within the page, so later bytes overwrite earlier ones, and only the bytes that were received are stored.
- R6: A write is committed only if chip select rises on a byte boundary after at least one whole data byte. A rise anywhere else, or with no data byte, leaves the array unchanged and starts no write cycle.
- R7: The set and clear write-enable commands act only when chip select rises directly after their 8th bit. A write or status write issued while the write-enable latch (status bit 1) is clear is ignored.
- R8: A committed write holds write-in-progress (status bit 0) for WC_CYCLES clocks. The bytes are then stored and the write-enable latch is cleared.
- R9: While a write cycle runs, the read, write, status-write and both write-enable commands are ignored, and status read still works.
- R10: If chip select is low when reset is released, nothing is accepted until chip select has gone high and then low.
- R11: Status write sets bit 7 (guard enable) and bits 3:2 (protection select, driven on `prot_sel`). Bits 6:4 read as 0. The new value takes effect on a chip-select rise right after the 8th data bit and clears the write-enable latch. The write is refused while bit 7 is 1 and `sr_guard` is high.
- R12: If `arr_wr_block` is high when chip select rises, the write is discarded and no write cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Serial out drive enable (high = drive) |
| sr_guard | input | 1 | Guard pin state from the protection unit (high = guard active) |
| arr_wr_block | input | 1 | Veto of the pending array write from the protection unit |
| prot_sel | output | 2 | Protection-select status bits 3:2 |

## Verification
The bench targets the commit rule. It covers trailing bits after the last data byte, an address with no data, and a write made while the latch is clear. A design that counts bits wrongly would store a torn byte or start a write cycle with nothing in it. A 34-byte write that starts two bytes before a page end checks in-page wrap and overwrite, and a read across the top address checks the array wrap; an off-by-one in either counter puts bytes in the wrong cells. The bench also checks the write-enable commands that are cut short, the commands refused during a write cycle, the guarded status write and the power-up select rule. A design that got any of these wrong would set or keep the latch, or answer a command, when it should stay silent.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_SRD,
        ST_SWR,
        ST_SWR_ARM,
        ST_WE_ARM,
        ST_SKIP
    } eep_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s
);
    // cs stages reset low so a select held low through reset shows no fall (R10)
    logic [2:0] cs_q;
    logic [2:0] sck_q;
    logic [1:0] sdi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= '0;
            sck_q <= '0;
            sdi_q <= '0;
        end else begin
            cs_q  <= {cs_q[1:0], cs_n};
            sck_q <= {sck_q[1:0], sck};
            sdi_q <= {sdi_q[0], sdi};
        end
    end

    assign cs_fall  = cs_q[2] & ~cs_q[1];
    assign cs_rise  = ~cs_q[2] & cs_q[1];
    assign sck_rise = ~sck_q[2] & sck_q[1];
    assign sck_fall = sck_q[2] & ~sck_q[1];
    assign sdi_s    = sdi_q[1];
endmodule

// File: rtl/eep_wc_timer.sv
module eep_wc_timer #(
    parameter int WC_CYCLES = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WC_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WC_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end

    assign done = busy && (cnt == LAST);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    assert_wip_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_wip_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          wr,
    input  logic [PAGE_W-1:0]             wr_col,
    input  logic [7:0]                    wr_byte,
    output logic [(1<<PAGE_W)-1:0][7:0]   data,
    output logic [(1<<PAGE_W)-1:0]        mask
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data[g] <= '0;
                mask[g] <= 1'b0;
            end else if (clr) begin
                mask[g] <= 1'b0;
            end else if (wr && (wr_col == PAGE_W'(g))) begin
                data[g] <= wr_byte;
                mask[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [7:0]                      rd_data,
    input  logic                            commit,
    input  logic [ADDR_W-PAGE_W-1:0]        page_base,
    input  logic [(1<<PAGE_W)-1:0][7:0]     page_data,
    input  logic [(1<<PAGE_W)-1:0]          page_mask
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (page_mask[j]) mem[{page_base, PAGE_W'(j)}] <= page_data[j];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ser_eeprom.sv
module ser_eeprom #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 5,
    parameter int WC_CYCLES = 1500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       sdi,
    output logic       sdo,
    output logic       sdo_en,
    input  logic       sr_guard,
    input  logic       arr_wr_block,
    output logic [1:0] prot_sel
);
    import eep_pkg::*;

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int BASE_W     = ADDR_W - PAGE_W;

    eep_state_e st, nxt;

    logic ev_cs_f, ev_cs_r, ev_sck_r, ev_sck_f, sdi_s;
    logic [14:0]       sh;
    logic [3:0]        bitn;
    logic [7:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PAGE_W-1:0] col;
    logic [BASE_W-1:0] pg_base;
    logic              byte_seen, wel, lock_en;
    logic [1:0]        bp;
    logic [7:0]        tx, src;
    logic [2:0]        txn;
    logic              sdo_q;
    logic              busy, wc_done, wc_start, pb_clr, pb_wr;
    logic [7:0]        rd_data, status, rx_byte;
    logic [15:0]       rx_addr;
    logic [PAGE_BYTES-1:0][7:0] pb_data;
    logic [PAGE_BYTES-1:0]      pb_mask;

    spi_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .cs_fall(ev_cs_f), .cs_rise(ev_cs_r), .sck_rise(ev_sck_r),
        .sck_fall(ev_sck_f), .sdi_s(sdi_s)
    );

    eep_wc_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(wc_start), .busy(busy), .done(wc_done)
    );

    eep_page_buf #(.PAGE_W(PAGE_W)) u_page (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr(pb_wr), .wr_col(col),
        .wr_byte(rx_byte), .data(pb_data), .mask(pb_mask)
    );

    eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr_q), .rd_data(rd_data),
        .commit(wc_done), .page_base(pg_base), .page_data(pb_data),
        .page_mask(pb_mask)
    );

    assign rx_byte  = {sh[6:0], sdi_s};
    assign rx_addr  = {sh, sdi_s};
    assign status   = {lock_en, 3'b000, bp, wel, busy};
    assign prot_sel = bp;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        if (ev_cs_r) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (ev_cs_f) nxt = ST_CMD;
                ST_CMD: if (ev_sck_r && bitn == 4'd7) begin
                    case (rx_byte)
                        OP_READ:  nxt = busy ? ST_SKIP : ST_ADDR;
                        OP_WRITE: nxt = (busy || !wel) ? ST_SKIP : ST_ADDR;
                        OP_WREN,
                        OP_WRDI:  nxt = busy ? ST_SKIP : ST_WE_ARM;
                        OP_RDSR:  nxt = ST_SRD;
                        OP_WRSR:  nxt = (busy || !wel) ? ST_SKIP : ST_SWR;
                        default:  nxt = ST_SKIP;
                    endcase
                end
                ST_ADDR: if (ev_sck_r && bitn == 4'd15)
                    nxt = (op_q == OP_READ) ? ST_RDATA : ST_WDATA;
                ST_SWR: if (ev_sck_r && bitn == 4'd7) nxt = ST_SWR_ARM;
                ST_SWR_ARM, ST_WE_ARM: if (ev_sck_r) nxt = ST_SKIP;
                ST_RDATA, ST_WDATA, ST_SRD, ST_SKIP: nxt = st;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // strobes towards the page latch and write timer
    always_comb begin
        pb_clr   = ev_sck_r && (st == ST_ADDR) && (bitn == 4'd15) && (op_q == OP_WRITE);
        pb_wr    = ev_sck_r && (st == ST_WDATA) && (bitn == 4'd7);
        wc_start = ev_cs_r && (st == ST_WDATA) && (bitn == 4'd0) && byte_seen
                   && !arr_wr_block;
        src      = (txn == 3'd0) ? ((st == ST_RDATA) ? rd_data : status) : tx;
        sdo_en   = (st == ST_RDATA) || (st == ST_SRD);
    end

    assign sdo = sdo_q;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0; bitn <= '0; op_q <= '0; addr_q <= '0; col <= '0;
            pg_base <= '0; byte_seen <= 1'b0; wel <= 1'b0; lock_en <= 1'b0;
            bp <= '0; tx <= '0; txn <= '0; sdo_q <= 1'b0;
        end else begin
            if (ev_cs_f) begin
                bitn      <= '0;
                byte_seen <= 1'b0;
                txn       <= '0;
            end
            if (ev_sck_r) begin
                case (st)
                    ST_CMD: begin
                        sh <= rx_addr[14:0];
                        if (bitn == 4'd7) begin
                            bitn <= '0;
                            op_q <= rx_byte;
                        end else bitn <= bitn + 1'b1;
                    end
                    ST_ADDR: begin
                        sh   <= rx_addr[14:0];
                        bitn <= bitn + 1'b1;
                        if (bitn == 4'd15) begin
                            addr_q <= rx_addr[ADDR_W-1:0];
                            col    <= rx_addr[PAGE_W-1:0];
                        end
                    end
                    ST_WDATA, ST_SWR: begin
                        sh <= rx_addr[14:0];
                        if (bitn == 4'd7) begin
                            bitn <= '0;
                            if (st == ST_WDATA) begin
                                col       <= col + 1'b1;
                                byte_seen <= 1'b1;
                            end
                        end else bitn <= bitn + 1'b1;
                    end
                    default: ;
                endcase
            end
            if (ev_sck_f && ((st == ST_RDATA) || (st == ST_SRD))) begin
                sdo_q <= src[7];
                tx    <= {src[6:0], 1'b0};
                txn   <= txn + 1'b1;
                if ((st == ST_RDATA) && (txn == 3'd7)) addr_q <= addr_q + 1'b1;
            end
            if (ev_cs_r) begin
                if (st == ST_WE_ARM) wel <= (op_q == OP_WREN);
                if ((st == ST_SWR_ARM) && !(lock_en && sr_guard)) begin
                    lock_en <= sh[7];
                    bp      <= sh[3:2];
                    wel     <= 1'b0;
                end
            end
            if (wc_start) pg_base <= addr_q[ADDR_W-1:PAGE_W];
            if (wc_done)  wel <= 1'b0;
        end
    end

    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cs_r |=> !sdo_en);
    assert_wel_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wc_done |=> !wel);
    assert_commit_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wc_start |=> busy);
    assert_wel_from_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> ($past(st) == ST_WE_ARM));
endmodule

// File: tb/tb_ser_eeprom.sv
module tb_ser_eeprom;
    localparam int CLK_P = 10;
    localparam int HALF  = 8 * CLK_P;
    localparam int AW    = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic sr_guard = 1'b0, arr_wr_block = 1'b0;
    logic sdo, sdo_en;
    logic [1:0] prot_sel;

    int n_chk = 0, n_fail = 0;
    logic en_seen;
    logic [7:0] wbuf [64];
    logic [7:0] rbuf [64];
    logic [7:0] model [1 << AW];

    always #(CLK_P / 2) clk = ~clk;

    ser_eeprom #(.ADDR_W(AW), .PAGE_W(5), .WC_CYCLES(1500)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .sr_guard(sr_guard),
        .arr_wr_block(arr_wr_block), .prot_sel(prot_sel)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i];
            #(HALF);
            r[i] = sdo;
            en_seen = sdo_en;
            sck = 1'b1;
            #(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sdi = 1'b1; #(HALF); sck = 1'b1; #(HALF); sck = 1'b0;
        end
    endtask

    task automatic sel();   cs_n = 1'b0; #(4 * CLK_P); endtask
    task automatic desel(); #(4 * CLK_P); cs_n = 1'b1; #(6 * CLK_P); endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel(); xfer(op, r); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 40; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    // sends a write with n bytes from wbuf, then extra bits, and deselects
    task automatic do_write(input logic [15:0] a, input int n, input int extra);
        logic [7:0] r;
        sel();
        xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r);
        for (int k = 0; k < n; k++) xfer(wbuf[k], r);
        pulses(extra);
        desel();
    endtask

    task automatic do_read(input logic [15:0] a, input int n);
        logic [7:0] r;
        sel();
        xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r);
        for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k]);
        desel();
    endtask

    task automatic t_powerup();
        logic [7:0] r;
        // cs_n held low through reset release: R10
        xfer(8'h05, r); xfer(8'h00, r);
        chk("R10 no response before first select", en_seen, 1'b0);
        desel();
        chk("R2 sdo_en low when deselected", sdo_en, 1'b0);
        rdsr(r);
        chk("R11 status after reset", r, 8'h00);
        chk("R2 sdo_en driven during status read", en_seen, 1'b1);
    endtask

    task automatic t_wel();
        logic [7:0] s, r;
        cmd1(8'h06); rdsr(s);
        chk("R7 enable sets bit1", s, 8'h02);
        cmd1(8'h04); rdsr(s);
        chk("R7 disable clears bit1", s, 8'h00);
        sel(); xfer(8'h06, r); pulses(1); desel(); rdsr(s);
        chk("R7 enable with trailing bit ignored", s, 8'h00);
    endtask

    task automatic t_write_nowel();
        logic [7:0] s;
        wbuf[0] = 8'h5A;
        do_write(16'h0010, 1, 0); rdsr(s);
        chk("R7 write without latch starts nothing", s, 8'h00);
        do_read(16'h0010, 1);
        chk("R7 write without latch leaves array", rbuf[0], model[16'h010]);
    endtask

    task automatic t_byte_write();
        logic [7:0] s;
        cmd1(8'h06);
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        do_write(16'h0010, 3, 0);
        for (int k = 0; k < 3; k++) model[16 + k] = wbuf[k];
        do_read(16'h0010, 1);
        chk("R9 array read refused during cycle", en_seen, 1'b0);
        rdsr(s);
        chk("R8 busy and latch during cycle", s, 8'h03);
        cmd1(8'h06);
        wait_idle(); rdsr(s);
        chk("R9 R8 enable ignored while busy, latch cleared", s, 8'h00);
        do_read(16'h0010, 3);
        for (int k = 0; k < 3; k++) chk("R5 R8 stored bytes", rbuf[k], model[16 + k]);
    endtask

    task automatic t_page_wrap();
        cmd1(8'h06);
        for (int k = 0; k < 34; k++) begin
            wbuf[k] = 8'h40 + 8'(k);
            model[16'h060 + ((30 + k) % 32)] = wbuf[k];
        end
        do_write(16'h007E, 34, 0);
        wait_idle();
        do_read(16'h0060, 32);
        for (int k = 0; k < 32; k++) chk("R5 page wrap contents", rbuf[k], model[16'h060 + k]);
    endtask

    task automatic t_partial();
        logic [7:0] s;
        cmd1(8'h06);
        wbuf[0] = 8'h3C;
        do_write(16'h0100, 1, 3); rdsr(s);
        chk("R6 torn byte starts no cycle", s, 8'h02);
        do_write(16'h0100, 0, 0); rdsr(s);
        chk("R6 address only starts no cycle", s, 8'h02);
        do_read(16'h0100, 1);
        chk("R6 array unchanged", rbuf[0], model[16'h100]);
        cmd1(8'h04);
    endtask

    task automatic t_addr_high();
        cmd1(8'h06);
        wbuf[0] = 8'h77;
        do_write(16'hF905, 1, 0);
        model[16'h105] = 8'h77;
        wait_idle();
        do_read(16'h0105, 1);
        chk("R3 upper address bits ignored", rbuf[0], 8'h77);
    endtask

    task automatic t_read_wrap();
        cmd1(8'h06); wbuf[0] = 8'h11; do_write(16'h07FF, 1, 0); model[16'h7FF] = 8'h11; wait_idle();
        cmd1(8'h06); wbuf[0] = 8'h22; do_write(16'h0000, 1, 0); model[0] = 8'h22; wait_idle();
        do_read(16'h07FE, 3);
        chk("R4 byte before top", rbuf[0], model[16'h7FE]);
        chk("R4 top byte", rbuf[1], 8'h11);
        chk("R4 wrap to zero", rbuf[2], 8'h22);
    endtask

    task automatic t_unknown();
        logic [7:0] r, s;
        sel(); xfer(8'h55, r); xfer(8'h05, r); xfer(8'h00, r);
        chk("R1 unknown code keeps sdo off", en_seen, 1'b0);
        desel(); rdsr(s);
        chk("R1 unknown code changes nothing", s, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] r, s;
        cmd1(8'h06); sel(); xfer(8'h01, r); xfer(8'h8C, r); desel(); rdsr(s);
        chk("R11 status write", s, 8'h8C);
        chk("R11 prot_sel follows bits 3:2", prot_sel, 2'b11);
        sr_guard = 1'b1;
        cmd1(8'h06); sel(); xfer(8'h01, r); xfer(8'h00, r); desel(); rdsr(s);
        chk("R11 guarded status write refused", s, 8'h8E);
        sr_guard = 1'b0;
        sel(); xfer(8'h01, r); xfer(8'h00, r); desel(); rdsr(s);
        chk("R11 unguarded status write", s, 8'h00);
        cmd1(8'h06); sel(); xfer(8'h01, r); xfer(8'h74, r); desel(); rdsr(s);
        chk("R11 bits 6:4 read zero", s, 8'h04);
        cmd1(8'h06); sel(); xfer(8'h01, r); xfer(8'h00, r); desel();
    endtask

    task automatic t_block();
        logic [7:0] s;
        arr_wr_block = 1'b1;
        cmd1(8'h06); wbuf[0] = 8'h99;
        do_write(16'h0200, 1, 0); rdsr(s);
        chk("R12 vetoed write starts no cycle", s, 8'h02);
        arr_wr_block = 1'b0;
        cmd1(8'h04);
        do_read(16'h0200, 1);
        chk("R12 vetoed write leaves array", rbuf[0], model[16'h200]);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
        #2;
        #(5 * CLK_P);
        rst_n = 1'b1;
        #(6 * CLK_P);
        t_powerup();
        t_wel();
        t_write_nowel();
        t_byte_write();
        t_page_wrap();
        t_partial();
        t_addr_high();
        t_read_wrap();
        t_unknown();
        t_status();
        t_block();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule